// File: doc/BRIEF.md
# Boot alias address remapper

This block lets firmware make a power-of-two segment of a 512 KB non-volatile memory appear at the address window that starts at 0x00000000. A 32-bit control register holds an enable bit and a base offset. A separate 5-bit size code sets the window size to 2^(code+1) bytes. The size code also sets how many base bits take part in translation: only base bits at and above position code+1 are used.

On the bus side the block takes an address and an access direction. In the same cycle it returns the physical memory offset, a flag that says the address fell inside the active alias window, and two refusal flags.

Writes that come through the alias are always refused. A write to the physical address is refused only when the region is not writable. Reads are refused only when the region is not readable, and the alias plays no part in that decision.

Top module: `alias_remap_top`

## Requirements
- R1: After reset the control register reads as 0x00000000, aliasing is off, and bus offsets pass through unchanged.
- R2: Register bits [31:19] always read as zero, whatever value was written to them.
- R3: A register write is accepted only when `cfg_size` is 2'b10 (32-bit). The read value holds {13'b0, wdata[18:0]} from the next cycle. A write of any other size leaves the register unchanged.
- R4: While the enable bit (register bit 0) is 0, `alias_hit` stays 0 for every address.
- R5: While the enable bit is 1, `alias_hit` is 1 exactly when every bus address bit at position N = size_code+1 or above is zero. When N is 32, every address hits.
- R6: On a hit, `phys_ofs[i]` is taken from register bit i for i >= N and from `bus_addr[i]` for i < N. Base bits below N have no effect. When N >= 19, no base bits are used.
- R7: On a miss, `phys_ofs` equals `bus_addr[18:0]`.
- R8: `wr_block` is 1 for a write that hits the alias, even when `region_wr_ok` is 1. For a write that misses, `wr_block` equals `!region_wr_ok`. For a read, `wr_block` is 0.
- R9: `rd_block` is 1 only for a read with `region_rd_ok` at 0, whether or not the read hits the alias. For a write, `rd_block` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_size | input | 2 | Access size of the write (2'b10 means 32-bit) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Stored register value |
| size_code | input | 5 | Window size code; window is 2^(code+1) bytes |
| bus_addr | input | 32 | Incoming bus address |
| bus_write | input | 1 | 1 for a write access, 0 for a read |
| region_rd_ok | input | 1 | Target region may be read |
| region_wr_ok | input | 1 | Target region may be written |
| phys_ofs | output | 19 | Translated memory offset |
| alias_hit | output | 1 | Address lies inside the active alias window |
| wr_block | output | 1 | Write refused |
| rd_block | output | 1 | Read refused |

## Verification
A uniformly random 32-bit address almost never has all its upper bits zero, so random addresses would leave the hit-side splicing nearly unexercised.

To reach the hits, the stimulus masks each address down to a random number of low bits between 0 and 20. It sweeps every size code from 0 to 31 under a random base with junk below the alignment point. Addresses then fall just inside and just outside the window edge.

The sweep also covers codes 18 to 31, where the base contributes nothing.

// File: rtl/alias_remap_pkg.sv
package alias_remap_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFS_W    = 19;
  localparam int CODE_W   = 5;
  localparam int REG_W    = 32;
  localparam int SIZE_W   = 2;
  localparam logic [SIZE_W-1:0] SIZE_WORD = 2'b10;

  // window edge: number of low address bits that come from the bus
  function automatic int unsigned edge_bit(input logic [CODE_W-1:0] code);
    return int'(code) + 1;
  endfunction
endpackage

// File: rtl/alias_ctrl_reg.sv
module alias_ctrl_reg #(
  parameter int REG_W  = 32,
  parameter int OFS_W  = 19,
  parameter int SIZE_W = 2,
  parameter logic [SIZE_W-1:0] FULL_SIZE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SIZE_W-1:0] size,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  q,
  output logic              accept
);
  localparam int RSV_W = REG_W - OFS_W;

  logic [OFS_W-1:0] live_q;

  assign accept = we && (size == FULL_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (accept) live_q <= wdata[OFS_W-1:0];
  end

  assign q = {{RSV_W{1'b0}}, live_q};
endmodule

// File: rtl/alias_xlate.sv
module alias_xlate
  import alias_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 19,
  parameter int CODE_W = 5
) (
  input  logic              enable,
  input  logic [OFS_W-1:0]  base,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  int unsigned edge_n;
  logic        upper_clear;

  always_comb begin
    edge_n      = edge_bit(code);
    upper_clear = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= int'(edge_n) && addr[i]) upper_clear = 1'b0;
    end
    hit = enable && upper_clear;
    for (int i = 0; i < OFS_W; i++) begin
      ofs[i] = (hit && i >= int'(edge_n)) ? base[i] : addr[i];
    end
  end
endmodule

// File: rtl/alias_guard.sv
module alias_guard (
  input  logic is_write,
  input  logic hit,
  input  logic rd_ok,
  input  logic wr_ok,
  output logic wr_block,
  output logic rd_block
);
  assign wr_block = is_write && (hit || !wr_ok);
  assign rd_block = !is_write && !rd_ok;
endmodule

// File: rtl/alias_remap_top.sv
module alias_remap_top
  import alias_remap_pkg::*;
#(
  parameter int ADDR_W = alias_remap_pkg::ADDR_W,
  parameter int OFS_W  = alias_remap_pkg::OFS_W,
  parameter int CODE_W = alias_remap_pkg::CODE_W,
  parameter int REG_W  = alias_remap_pkg::REG_W,
  parameter int SIZE_W = alias_remap_pkg::SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [CODE_W-1:0] size_code,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              region_rd_ok,
  input  logic              region_wr_ok,
  output logic [OFS_W-1:0]  phys_ofs,
  output logic              alias_hit,
  output logic              wr_block,
  output logic              rd_block
);
  logic [REG_W-1:0] cfg_q;
  logic             cfg_accept;
  logic             cfg_en;
  logic [OFS_W-1:0] cfg_base;

  alias_ctrl_reg #(
    .REG_W(REG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W), .FULL_SIZE(SIZE_WORD)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .size(cfg_size),
    .wdata(cfg_wdata), .q(cfg_q), .accept(cfg_accept)
  );

  assign cfg_en    = cfg_q[0];
  assign cfg_base  = cfg_q[OFS_W-1:0];
  assign cfg_rdata = cfg_q;

  alias_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CODE_W(CODE_W)) u_xlate (
    .enable(cfg_en), .base(cfg_base), .code(size_code), .addr(bus_addr),
    .hit(alias_hit), .ofs(phys_ofs)
  );

  alias_guard u_guard (
    .is_write(bus_write), .hit(alias_hit), .rd_ok(region_rd_ok),
    .wr_ok(region_wr_ok), .wr_block(wr_block), .rd_block(rd_block)
  );
endmodule

// File: rtl/alias_remap_chk.sv
module alias_remap_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 19,
  parameter int CODE_W = 5,
  parameter int REG_W  = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [SIZE_W-1:0] cfg_size,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic [CODE_W-1:0] size_code,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              region_rd_ok,
  input logic              region_wr_ok,
  input logic [OFS_W-1:0]  phys_ofs,
  input logic              alias_hit,
  input logic              wr_block,
  input logic              rd_block,
  input logic              cfg_accept
);
  localparam int RSV_W = REG_W - OFS_W;

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:OFS_W] == '0);
  // R3
  size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_size != 2'b10) |=> $stable(cfg_rdata));
  // R3
  word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |=> cfg_rdata == {{RSV_W{1'b0}}, $past(cfg_wdata[OFS_W-1:0])});
  // R4
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> !alias_hit);
  // R5
  hit_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_hit && size_code < 5'd18) |-> bus_addr[ADDR_W-1:OFS_W] == '0);
  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_hit |-> phys_ofs == bus_addr[OFS_W-1:0]);
  // R8
  alias_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && alias_hit) |-> wr_block);
  // R8
  phys_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && !alias_hit) |-> wr_block == !region_wr_ok);
  // R9
  rd_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_write |-> (!wr_block && rd_block == !region_rd_ok));
endmodule

bind alias_remap_top alias_remap_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .REG_W(REG_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .size_code(size_code),
  .bus_addr(bus_addr), .bus_write(bus_write), .region_rd_ok(region_rd_ok),
  .region_wr_ok(region_wr_ok), .phys_ofs(phys_ofs), .alias_hit(alias_hit),
  .wr_block(wr_block), .rd_block(rd_block), .cfg_accept(cfg_accept)
);

// File: tb/tb_alias_remap_top.sv
module tb_alias_remap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_size = 2'b00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [4:0]  size_code = '0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        region_rd_ok = 1'b1;
  logic        region_wr_ok = 1'b1;
  logic [18:0] phys_ofs;
  logic        alias_hit, wr_block, rd_block;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint m_reg = 0;

  always #5 clk = ~clk;

  alias_remap_top dut (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, let the clock edge pass, compare at the next negedge
  task automatic step(input bit we, input logic [1:0] sz, input logic [31:0] wd,
                      input logic [4:0] code, input logic [31:0] a,
                      input bit wr, input bit rok, input bit wok);
    longint n, mask, ea, eo;
    bit en, hit;
    cfg_we = we; cfg_size = sz; cfg_wdata = wd; size_code = code;
    bus_addr = a; bus_write = wr; region_rd_ok = rok; region_wr_ok = wok;
    @(posedge clk);
    if (we && sz == 2'b10) m_reg = longint'(wd) & 64'h7FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    en   = m_reg[0];
    n    = longint'(code) + 1;
    ea   = longint'(a);
    hit  = en && ((ea >> n) == 0);
    mask = (longint'(1) << n) - 1;
    eo   = hit ? (((m_reg & ~mask) | (ea & mask)) & 64'h7FFFF) : (ea & 64'h7FFFF);
    check("R3 rdata", cfg_rdata, m_reg);
    check(en ? "R5 hit" : "R4 hit", alias_hit, hit);
    check(hit ? "R6 ofs" : "R7 ofs", phys_ofs, eo);
    check("R8 wr_block", wr_block, wr && (hit || !wok));
    check("R9 rd_block", rd_block, !wr && !rok);
  endtask

  function automatic logic [31:0] pick_addr();
    int k = $urandom_range(0, 21);
    logic [31:0] r = $urandom;
    if (k == 21) return r;
    return r & ((32'h1 << k) - 1);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value held while reset is active
    check("R1 reset rdata", cfg_rdata, 0);
    check("R1 reset hit", alias_hit, 0);
    check("R1 reset ofs", phys_ofs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: disabled, no translation
    for (int i = 0; i < 20; i++)
      step(0, 2'b00, 0, 5'($urandom), pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom));
    // R2: all-ones write, reserved bits must read zero
    step(1, 2'b10, 32'hFFFF_FFFF, 5'd15, 32'h0, 0, 1, 1);
    check("R2 reserved", cfg_rdata[31:19], 0);
    // R3: sub-word sizes ignored
    for (int s = 0; s < 4; s++)
      if (s != 2) step(1, 2'(s), 32'h0001_2340, 5'd15, 32'h10, 0, 1, 1);
    check("R3 narrow ignored", cfg_rdata, 32'h7FFFF);
    // R6: 64 KB window, base 0x30000 with junk below the edge
    step(1, 2'b10, 32'h0003_0ABD, 5'd15, 32'h0000_1234, 0, 1, 1);
    check("R6 64KB splice", phys_ofs, 19'h31234);
    // R8: alias write refused though region is writable
    step(0, 2'b00, 0, 5'd15, 32'h0000_1234, 1, 1, 1);
    check("R8 alias write", wr_block, 1);
    // R8: physical write allowed
    step(0, 2'b00, 0, 5'd15, 32'h0003_1234, 1, 1, 1);
    check("R8 phys write", wr_block, 0);
    // R9: read through alias not refused
    step(0, 2'b00, 0, 5'd15, 32'h0000_0020, 0, 1, 0);
    check("R9 alias read", rd_block, 0);
    // sweep every size code with random base and enable
    for (int c = 0; c < 32; c++) begin
      step(1, 2'b10, $urandom | 32'h1, 5'(c), 0, 0, 1, 1);
      for (int j = 0; j < 40; j++)
        step(($urandom_range(0, 15) == 0), 2'($urandom), $urandom, 5'(c), pick_addr(),
             1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule